// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block routes bus addresses to one of two on-chip memories: a 64 KB flash and an 8 KB SRAM. The bottom of the address space is a mirror window, and that window is served by either the flash or the SRAM. The exception vectors sit at its very start. A one-bit control register chooses which memory the window aliases. Each memory also keeps a fixed home range, and that range reaches it whatever the control bit holds. Addresses outside all three ranges are flagged as errors.

Requests arrive on a valid/ready stream and leave one cycle later on a second valid/ready stream. Each response carries the chosen memory, the byte offset inside that memory and an error flag.

Back-pressure rules:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high when the response slot is empty, or when the slot is being drained in that same cycle.
- While `resp_valid` is high and `resp_ready` is low, every response field holds its value.

The control register has a plain write strobe and a read bus that is always live. Two kinds of reset return the window to flash:
- the asynchronous `rst_n`;
- a synchronous `rst_req` pulse that stands in for the other reset sources, such as the watchdog or a software request.

Top module: `boot_remap_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `cfg_rdata` reads 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: With the remap bit at 0, an address below 0x00040000 selects the flash, and the offset is the address modulo 0x10000.
- R3: A write with `cfg_wdata[0]`=1 sets the remap bit. `cfg_rdata` shows 1 from the next cycle. Window addresses then select the SRAM, with the offset equal to the address modulo 0x2000.
- R4: A write with `cfg_wdata[0]`=0 clears the remap bit, and window addresses select the flash again.
- R5: Addresses 0x00040000 to 0x00041FFF always select the SRAM, with the offset equal to the address minus 0x00040000, whatever the remap bit holds.
- R6: Addresses 0x00080000 to 0x0008FFFF always select the flash, with the offset equal to the address minus 0x00080000, whatever the remap bit holds.
- R7: Any other address gives `resp_err`=1, with both select outputs at 0 and the offset at 0.
- R8: `cfg_rdata[31:1]` always read 0, and writes to those bits have no effect.
- R9: A cycle with `rst_req` high clears the remap bit and drops any pending response from the next cycle on. If a write happens in the same cycle, the reset wins.
- R10: An accepted request appears on the response port on the next cycle. It is decoded with the remap bit held before that edge, so a write in the same cycle does not affect it.
- R11: While `resp_valid`=1 and `resp_ready`=0, the response fields hold stable and `req_ready` is 0.
- R12: Whenever `resp_valid` is 1, exactly one of `resp_flash_sel`, `resp_sram_sel` and `resp_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Synchronous reset request from any other reset source |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data; only bit 0 is kept |
| cfg_rdata | output | 32 | Control register read data; remap bit in bit 0 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 32 | Request byte address |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response ready |
| resp_flash_sel | output | 1 | Response targets the flash |
| resp_sram_sel | output | 1 | Response targets the SRAM |
| resp_err | output | 1 | Address is unmapped |
| resp_offset | output | 16 | Byte offset inside the selected memory |

## Verification
The results fall due at different times:
- A decoded response is due one clock edge after its request is accepted.
- A register write shows on `cfg_rdata` one edge later.
- A `rst_req` pulse clears the bit and the pending response by the following edge.

The bench drives its inputs on the falling edge and samples exactly one rising edge later, at the next falling edge. In the back-pressure scenario it samples over several stalled cycles to confirm that the response holds. In the same-edge scenario it checks that the request just accepted was decoded with the old remap bit, and that the following request was decoded with the new one.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_SRAM  = 2'd2
  } target_e;

  typedef enum logic [1:0] {
    RGN_UNMAPPED   = 2'd0,
    RGN_MIRROR     = 2'd1,
    RGN_SRAM_HOME  = 2'd2,
    RGN_FLASH_HOME = 2'd3
  } region_e;

endpackage

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              remap_q,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - 1;

  // A synchronous reset request outranks a write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
    end else if (rst_req) begin
      remap_q <= 1'b0;
    end else if (wr_en) begin
      remap_q <= wr_bit;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, remap_q};
    end else begin : g_nopad
      assign rd_data = remap_q;
    end
  endgenerate

endmodule

// File: rtl/remap_addr_decode.sv
module remap_addr_decode
  import remap_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          OFF_W       = 16,
  parameter int unsigned WIN_END     = 32'h0004_0000,
  parameter int unsigned SRAM_BASE   = 32'h0004_0000,
  parameter int unsigned SRAM_BYTES  = 32'h0000_2000,
  parameter int unsigned FLASH_BASE  = 32'h0008_0000,
  parameter int unsigned FLASH_BYTES = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  output target_e           tgt,
  output logic [OFF_W-1:0]  offset
);

  localparam logic [ADDR_W-1:0] WIN_LIM   = ADDR_W'(WIN_END);
  localparam logic [ADDR_W-1:0] SRAM_LO   = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] SRAM_HI   = ADDR_W'(SRAM_BASE + SRAM_BYTES);
  localparam logic [ADDR_W-1:0] FLASH_LO  = ADDR_W'(FLASH_BASE);
  localparam logic [ADDR_W-1:0] FLASH_HI  = ADDR_W'(FLASH_BASE + FLASH_BYTES);
  localparam logic [ADDR_W-1:0] SRAM_MSK  = ADDR_W'(SRAM_BYTES - 1);
  localparam logic [ADDR_W-1:0] FLASH_MSK = ADDR_W'(FLASH_BYTES - 1);

  region_e           region;
  logic [ADDR_W-1:0] sram_rel;
  logic [ADDR_W-1:0] flash_rel;

  // Classify the address; the mirror window is checked first.
  always_comb begin
    if (addr < WIN_LIM) begin
      region = RGN_MIRROR;
    end else if (addr >= SRAM_LO && addr < SRAM_HI) begin
      region = RGN_SRAM_HOME;
    end else if (addr >= FLASH_LO && addr < FLASH_HI) begin
      region = RGN_FLASH_HOME;
    end else begin
      region = RGN_UNMAPPED;
    end
  end

  assign sram_rel  = addr - SRAM_LO;
  assign flash_rel = addr - FLASH_LO;

  // Inside the window the offset wraps modulo the size of the chosen memory.
  always_comb begin
    tgt    = TGT_NONE;
    offset = '0;
    unique case (region)
      RGN_MIRROR: begin
        if (remap) begin
          tgt    = TGT_SRAM;
          offset = OFF_W'(addr & SRAM_MSK);
        end else begin
          tgt    = TGT_FLASH;
          offset = OFF_W'(addr & FLASH_MSK);
        end
      end
      RGN_SRAM_HOME: begin
        tgt    = TGT_SRAM;
        offset = OFF_W'(sram_rel & SRAM_MSK);
      end
      RGN_FLASH_HOME: begin
        tgt    = TGT_FLASH;
        offset = OFF_W'(flash_rel & FLASH_MSK);
      end
      default: begin
        tgt    = TGT_NONE;
        offset = '0;
      end
    endcase
  end

endmodule

// File: rtl/remap_resp_stage.sv
module remap_resp_stage
  import remap_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  target_e          in_tgt,
  input  logic [OFF_W-1:0] in_off,
  output logic             out_valid,
  input  logic             out_ready,
  output target_e          out_tgt,
  output logic [OFF_W-1:0] out_off
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // The payload only changes when a new request is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_tgt <= TGT_NONE;
      out_off <= '0;
    end else if (take && !flush) begin
      out_tgt <= in_tgt;
      out_off <= in_off;
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import remap_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int unsigned WIN_END     = 32'h0004_0000,
  parameter int unsigned SRAM_BASE   = 32'h0004_0000,
  parameter int unsigned SRAM_BYTES  = 32'h0000_2000,
  parameter int unsigned FLASH_BASE  = 32'h0008_0000,
  parameter int unsigned FLASH_BYTES = 32'h0001_0000,
  localparam int         BIG_BYTES   = (SRAM_BYTES > FLASH_BYTES) ? SRAM_BYTES : FLASH_BYTES,
  localparam int         OFF_W       = $clog2(BIG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_flash_sel,
  output logic              resp_sram_sel,
  output logic              resp_err,
  output logic [OFF_W-1:0]  resp_offset
);

  logic             remap_q;
  target_e          dec_tgt;
  logic [OFF_W-1:0] dec_off;
  target_e          held_tgt;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:1];

  remap_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_req (rst_req),
    .wr_en   (cfg_wr),
    .wr_bit  (cfg_wdata[0]),
    .remap_q (remap_q),
    .rd_data (cfg_rdata)
  );

  remap_addr_decode #(
    .ADDR_W      (ADDR_W),
    .OFF_W       (OFF_W),
    .WIN_END     (WIN_END),
    .SRAM_BASE   (SRAM_BASE),
    .SRAM_BYTES  (SRAM_BYTES),
    .FLASH_BASE  (FLASH_BASE),
    .FLASH_BYTES (FLASH_BYTES)
  ) u_dec (
    .addr   (req_addr),
    .remap  (remap_q),
    .tgt    (dec_tgt),
    .offset (dec_off)
  );

  remap_resp_stage #(.OFF_W(OFF_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rst_req),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_tgt    (dec_tgt),
    .in_off    (dec_off),
    .out_valid (resp_valid),
    .out_ready (resp_ready),
    .out_tgt   (held_tgt),
    .out_off   (resp_offset)
  );

  assign resp_flash_sel = (held_tgt == TGT_FLASH);
  assign resp_sram_sel  = (held_tgt == TGT_SRAM);
  assign resp_err       = (held_tgt == TGT_NONE);

endmodule

// File: rtl/remap_decoder_checker.sv
module remap_decoder_checker #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req,
  input logic              cfg_wr,
  input logic              wbit,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_flash_sel,
  input logic              resp_sram_sel,
  input logic              resp_err,
  input logic [OFF_W-1:0]  resp_offset
);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:1] == '0);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !rst_req) |=> (cfg_rdata[0] == $past(wbit)));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (cfg_rdata[0] == 1'b0 && !resp_valid));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rst_req) |=> resp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready && !rst_req) |=>
      (resp_valid && $stable({resp_flash_sel, resp_sram_sel, resp_err, resp_offset})));

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_flash_sel, resp_sram_sel, resp_err}) == 1));

  assert_err_zero_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (resp_offset == '0));

endmodule

bind boot_remap_decoder remap_decoder_checker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_req        (rst_req),
  .cfg_wr         (cfg_wr),
  .wbit           (cfg_wdata[0]),
  .cfg_rdata      (cfg_rdata),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .resp_valid     (resp_valid),
  .resp_ready     (resp_ready),
  .resp_flash_sel (resp_flash_sel),
  .resp_sram_sel  (resp_sram_sel),
  .resp_err       (resp_err),
  .resp_offset    (resp_offset)
);

// File: tb/tb_boot_remap_decoder.sv
module tb_boot_remap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_flash_sel;
  logic        resp_sram_sel;
  logic        resp_err;
  logic [15:0] resp_offset;

  int checks = 0;
  int fails  = 0;
  logic mdl_remap = 1'b0;

  always #2.5 clk = ~clk;

  boot_remap_decoder dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rst_req        (rst_req),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_flash_sel (resp_flash_sel),
    .resp_sram_sel  (resp_sram_sel),
    .resp_err       (resp_err),
    .resp_offset    (resp_offset)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Packed expectation: {valid, flash, sram, err, offset[15:0]}
  function automatic logic [19:0] expect_route(logic [31:0] a, logic rm);
    if (a < 32'h0004_0000) begin
      if (rm) return {4'b1010, a[15:0] & 16'h1FFF};
      else    return {4'b1100, a[15:0]};
    end
    if (a >= 32'h0004_0000 && a <= 32'h0004_1FFF) return {4'b1010, 16'(a - 32'h0004_0000)};
    if (a >= 32'h0008_0000 && a <= 32'h0008_FFFF) return {4'b1100, 16'(a - 32'h0008_0000)};
    return {4'b1001, 16'h0000};
  endfunction

  function automatic logic [19:0] observed();
    return {resp_valid, resp_flash_sel, resp_sram_sel, resp_err, resp_offset};
  endfunction

  task automatic lookup(logic [31:0] a, string tag);
    @(negedge clk);
    req_addr   = a;
    req_valid  = 1'b1;
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, 32'(observed()), 32'(expect_route(a, mdl_remap)));
  endtask

  task automatic write_cfg(logic [31:0] d, string tag);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    mdl_remap = d[0];
    chk(tag, cfg_rdata, {31'd0, d[0]});
  endtask

  task automatic t_reset_state();
    chk("R1 rdata", cfg_rdata, 32'd0);
    chk("R1 valid/ready", {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_flash_window();
    lookup(32'h0000_0000, "R2 vector base");
    lookup(32'h0000_0020, "R2 vector top");
    lookup(32'h0003_5678, "R2 wrap 64K");
    lookup(32'h0003_FFFF, "R2 window edge");
  endtask

  task automatic t_sram_window();
    write_cfg(32'h0000_0001, "R3 readback");
    lookup(32'h0000_0020, "R3 vector");
    lookup(32'h0003_5678, "R3 wrap 8K");
    lookup(32'h0003_FFFF, "R3 window edge");
  endtask

  task automatic t_homes();
    lookup(32'h0004_0000, "R5 sram home lo");
    lookup(32'h0004_1FFC, "R5 sram home hi");
    lookup(32'h0008_0000, "R6 flash home lo");
    lookup(32'h0008_FFFF, "R6 flash home hi");
  endtask

  task automatic t_unmapped();
    lookup(32'h0004_2000, "R7 past sram");
    lookup(32'h0007_FFFF, "R7 below flash");
    lookup(32'h0009_0000, "R7 past flash");
    lookup(32'hFFFF_FFFF, "R7 top");
  endtask

  task automatic t_upper_bits();
    write_cfg(32'hFFFF_FFFE, "R8 ignore upper, clear bit");
    write_cfg(32'hFFFF_FFFF, "R8 ignore upper, set bit");
    lookup(32'h0000_2004, "R8 window still sram");
  endtask

  task automatic t_unremap();
    write_cfg(32'h0000_0000, "R4 readback");
    lookup(32'h0003_5678, "R4 flash back");
  endtask

  task automatic t_same_edge();
    // Write remap=1 and issue a request on the same edge: old value applies.
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 32'h1;
    req_addr = 32'h0000_3000; req_valid = 1'b1; resp_ready = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    chk("R10 old remap used", 32'(observed()), 32'(expect_route(32'h0000_3000, 1'b0)));
    mdl_remap = 1'b1;
    lookup(32'h0000_3000, "R10 new remap next");
  endtask

  task automatic t_backpressure();
    logic [19:0] first;
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0008_1234;
    @(negedge clk);
    first = expect_route(32'h0008_1234, mdl_remap);
    chk("R11 first response", 32'(observed()), 32'(first));
    req_addr = 32'h0004_0010;
    chk("R11 ready low", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 held", 32'(observed()), 32'(first));
    end
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second after drain", 32'(observed()), 32'(expect_route(32'h0004_0010, mdl_remap)));
    @(negedge clk);
    chk("R12 idle after drain", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_soft_reset();
    // remap is 1 here; pulse rst_req together with a write of 1 and a pending response.
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0000_0100;
    @(negedge clk);
    req_valid = 1'b0;
    rst_req = 1'b1; cfg_wr = 1'b1; cfg_wdata = 32'h1;
    @(negedge clk);
    rst_req = 1'b0; cfg_wr = 1'b0;
    mdl_remap = 1'b0;
    chk("R9 bit cleared", cfg_rdata, 32'd0);
    chk("R9 response dropped", {31'd0, resp_valid}, 32'd0);
    lookup(32'h0000_0100, "R9 window flash");
  endtask

  task automatic t_hard_reset();
    write_cfg(32'h1, "R3 set before hard reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    mdl_remap = 1'b0;
    chk("R1 during reset", cfg_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    lookup(32'h0000_0004, "R1 window flash after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_flash_window();
    t_homes();
    t_unmapped();
    t_sram_window();
    t_homes();
    t_unmapped();
    t_upper_bits();
    t_unremap();
    t_same_edge();
    t_backpressure();
    t_soft_reset();
    t_hard_reset();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule